// File: doc/BRIEF.md
# Byte-Wide SMBus Host Register Block

This block is the software-facing half of an SMBus host. Software programs a command byte, a target address byte, two data bytes and a 32-entry block buffer through a small byte-wide register window. It then writes the control register with the start bit set. The block takes a snapshot of the programmed fields and hands one transaction of the selected protocol to a downstream bus engine through a valid/ready request channel. Once the engine signals completion, read results land back in the data registers or in the block buffer.

The engine works at the byte level and owns all wire-level signalling. It reads outgoing block bytes and deposits incoming block bytes through dedicated random-access buffer ports. It reports completion with a single-cycle response strobe that carries up to sixteen bits of result. Unsupported protocol codes never reach the engine and only raise an error flag. The block buffer is reached from software through one auto-stepping window. Its pointer wraps at the last entry and returns to entry 0 on a status write or a control read.

Top module: `smb_host_ctrl`

## Requirements
- R1: The window decodes six offset bits: 0 status, 2 control, 3 command, 4 target address, 5 data0, 6 data1, 7 block data. Offsets 1 and 8 to 63 read 0, and writes to them change no register.
- R2: A control write with bit 6 set, while idle, issues one request. Its protocol is control bits 4:2 of the written byte, its target is address register bits 7:1, its read flag is address bit 0, and its command is the command register.
- R3: The request data field is {data1, data0}, except for protocol 1 with read flag 0, where it is {8'h00, command}. The length field always equals data0, which is the byte count for a block write.
- R4: Protocol codes 4, 6 and 7 issue no request and set status bit 2 (error).
- R5: The request valid stays high, with all request fields unchanged, until the cycle in which ready is sampled high.
- R6: Status bit 0 (busy) is 1 from the accepted start until the engine response. The response clears busy and sets status bit 1 (done). Status bits 7:3 read 0.
- R7: On a response to a read, protocols 1 and 2 load data0 from response bits 7:0. Protocol 3 loads data0 from bits 7:0 and data1 from bits 15:8. Protocol 5 loads data0 with the returned count in bits 7:0. Writes and quick commands leave data0 and data1 unchanged.
- R8: A control write with bit 6 set while busy issues no request. The written control value is still stored.
- R9: Any write to status clears done and error and returns the block pointer to entry 0.
- R10: A control read returns the stored control value AND 8'h1F and returns the block pointer to entry 0.
- R11: Each block-data read or write accesses the entry at the pointer and then advances the pointer, which wraps from 31 to 0. The engine reads any entry through its read port and writes any entry through its write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies read side effects) |
| reg_off | input | 6 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current offset |
| eng_req_valid | output | 1 | Request valid to the bus engine |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_proto | output | 3 | Protocol code |
| eng_tgt | output | 7 | 7-bit target address |
| eng_read | output | 1 | Read flag |
| eng_cmd | output | 8 | Command byte |
| eng_data | output | 16 | Outgoing data |
| eng_len | output | 8 | Block byte count |
| eng_rsp_valid | input | 1 | Engine completion strobe |
| eng_rsp_data | input | 16 | Completion data or returned block count |
| eng_buf_ridx | input | 5 | Engine buffer read index |
| eng_buf_rdata | output | 8 | Engine buffer read data |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_widx | input | 5 | Engine buffer write index |
| eng_buf_wdata | input | 8 | Engine buffer write data |

## Verification
The bench builds the block with its default 32-entry buffer. That size lets a single run write 33 block bytes and read 34, so the wrap from entry 31 and the overwrite of entry 0 are both observed through the software window and the engine read port. With a 3-bit protocol field, all eight codes are swept in both read and write directions, and each request field and each data-register write-back is compared with arithmetic expectations. The 6-bit offset space is small enough to probe every unmapped offset.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_STAT = 6'd0;
    localparam logic [OFF_W-1:0] OFF_CTL  = 6'd2;
    localparam logic [OFF_W-1:0] OFF_CMD  = 6'd3;
    localparam logic [OFF_W-1:0] OFF_ADR  = 6'd4;
    localparam logic [OFF_W-1:0] OFF_D0   = 6'd5;
    localparam logic [OFF_W-1:0] OFF_D1   = 6'd6;
    localparam logic [OFF_W-1:0] OFF_BLK  = 6'd7;

    localparam int CTL_START = 6;
    localparam int CTL_VIS_W = 5;

    typedef enum logic [2:0] {
        PR_QUICK = 3'd0,
        PR_BYTE  = 3'd1,
        PR_BDATA = 3'd2,
        PR_WORD  = 3'd3,
        PR_RSV4  = 3'd4,
        PR_BLOCK = 3'd5,
        PR_RSV6  = 3'd6,
        PR_RSV7  = 3'd7
    } proto_e;

    typedef struct packed {
        proto_e      proto;
        logic [6:0]  tgt;
        logic        rd;
        logic [7:0]  cmd;
        logic [15:0] data;
        logic [7:0]  len;
    } req_t;

    function automatic logic proto_ok(proto_e p);
        return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
               (p == PR_WORD)  || (p == PR_BLOCK);
    endfunction

    function automatic req_t make_req(logic [2:0] p, logic [7:0] adr,
                                      logic [7:0] cmd, logic [7:0] d0,
                                      logic [7:0] d1);
        req_t r;
        r.proto = proto_e'(p);
        r.tgt   = adr[7:1];
        r.rd    = adr[0];
        r.cmd   = cmd;
        r.data  = (r.proto == PR_BYTE && !adr[0]) ? {8'h00, cmd} : {d1, d0};
        r.len   = d0;
        return r;
    endfunction

endpackage

// File: rtl/smbh_seq.sv
module smbh_seq
    import smbh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  req_t req_in,
    input  logic eng_ready,
    input  logic eng_rsp_valid,
    output logic busy,
    output logic req_valid,
    output req_t req_q,
    output logic done_p,
    output logic err_p
);

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

    st_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            req_q <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start && proto_ok(req_in.proto)) begin
                        state <= S_REQ;
                        req_q <= req_in;
                    end
                end
                S_REQ: begin
                    if (eng_ready) state <= S_WAIT;
                end
                S_WAIT: begin
                    if (eng_rsp_valid) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        req_valid = (state == S_REQ);
        done_p    = (state == S_WAIT) && eng_rsp_valid;
        err_p     = (state == S_IDLE) && start && !proto_ok(req_in.proto);
    end

endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
    parameter  int DEPTH = 32,
    parameter  int W     = 8,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_step,
    input  logic          idx_clr,
    output logic [W-1:0]  host_rdata,
    output logic [IW-1:0] idx,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_widx,
    input  logic [W-1:0]  eng_wdata,
    input  logic [IW-1:0] eng_ridx,
    output logic [W-1:0]  eng_rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (idx_clr)
                idx <= '0;
            else if (host_step)
                idx <= (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
            if (host_we) mem[idx] <= host_wdata;
            if (eng_we)  mem[eng_widx] <= eng_wdata;
        end
    end

    assign host_rdata = mem[idx];
    assign eng_rdata  = mem[eng_ridx];

endmodule

// File: rtl/smb_host_ctrl.sv
module smb_host_ctrl
    import smbh_pkg::*;
#(
    parameter  int BUF_DEPTH = 32,
    localparam int IW        = $clog2(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             eng_req_valid,
    input  logic             eng_req_ready,
    output logic [2:0]       eng_proto,
    output logic [6:0]       eng_tgt,
    output logic             eng_read,
    output logic [7:0]       eng_cmd,
    output logic [15:0]      eng_data,
    output logic [7:0]       eng_len,
    input  logic             eng_rsp_valid,
    input  logic [15:0]      eng_rsp_data,
    input  logic [IW-1:0]    eng_buf_ridx,
    output logic [7:0]       eng_buf_rdata,
    input  logic             eng_buf_we,
    input  logic [IW-1:0]    eng_buf_widx,
    input  logic [7:0]       eng_buf_wdata
);

    logic [CTL_VIS_W-1:0] ctl_q;
    logic [7:0]           cmd_q, adr_q, d0_q, d1_q;
    logic                 stat_done, stat_err;
    logic                 busy, done_p, err_p;
    logic                 stat_wr, ctl_wr, ctl_rd, blk_acc, start;
    logic [IW-1:0]        blk_idx;
    logic [7:0]           blk_rdata;
    req_t                 req_in, req_q;

    always_comb begin
        stat_wr = reg_wr && (reg_off == OFF_STAT);
        ctl_wr  = reg_wr && (reg_off == OFF_CTL);
        ctl_rd  = reg_rd && (reg_off == OFF_CTL);
        blk_acc = (reg_wr || reg_rd) && (reg_off == OFF_BLK);
        start   = ctl_wr && reg_wdata[CTL_START];
        req_in  = make_req(reg_wdata[4:2], adr_q, cmd_q, d0_q, d1_q);
    end

    smbh_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .req_in        (req_in),
        .eng_ready     (eng_req_ready),
        .eng_rsp_valid (eng_rsp_valid),
        .busy          (busy),
        .req_valid     (eng_req_valid),
        .req_q         (req_q),
        .done_p        (done_p),
        .err_p         (err_p)
    );

    smbh_blkbuf #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .host_we    (reg_wr && (reg_off == OFF_BLK)),
        .host_wdata (reg_wdata),
        .host_step  (blk_acc),
        .idx_clr    (stat_wr || ctl_rd),
        .host_rdata (blk_rdata),
        .idx        (blk_idx),
        .eng_we     (eng_buf_we),
        .eng_widx   (eng_buf_widx),
        .eng_wdata  (eng_buf_wdata),
        .eng_ridx   (eng_buf_ridx),
        .eng_rdata  (eng_buf_rdata)
    );

    // host register writes, then engine write-back on completion
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmd_q <= '0;
            adr_q <= '0;
            d0_q  <= '0;
            d1_q  <= '0;
        end else begin
            if (ctl_wr) ctl_q <= reg_wdata[CTL_VIS_W-1:0];
            if (reg_wr && reg_off == OFF_CMD) cmd_q <= reg_wdata;
            if (reg_wr && reg_off == OFF_ADR) adr_q <= reg_wdata;
            if (reg_wr && reg_off == OFF_D0)  d0_q  <= reg_wdata;
            if (reg_wr && reg_off == OFF_D1)  d1_q  <= reg_wdata;
            if (done_p && req_q.rd) begin
                case (req_q.proto)
                    PR_BYTE, PR_BDATA, PR_BLOCK: d0_q <= eng_rsp_data[7:0];
                    PR_WORD: begin
                        d0_q <= eng_rsp_data[7:0];
                        d1_q <= eng_rsp_data[15:8];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_done <= 1'b0;
            stat_err  <= 1'b0;
        end else begin
            if (stat_wr) begin
                stat_done <= 1'b0;
                stat_err  <= 1'b0;
            end
            if (done_p) stat_done <= 1'b1;
            if (err_p)  stat_err  <= 1'b1;
        end
    end

    always_comb begin
        case (reg_off)
            OFF_STAT: reg_rdata = {5'b0, stat_err, stat_done, busy};
            OFF_CTL:  reg_rdata = {{(8-CTL_VIS_W){1'b0}}, ctl_q};
            OFF_CMD:  reg_rdata = cmd_q;
            OFF_ADR:  reg_rdata = adr_q;
            OFF_D0:   reg_rdata = d0_q;
            OFF_D1:   reg_rdata = d1_q;
            OFF_BLK:  reg_rdata = blk_rdata;
            default:  reg_rdata = 8'h00;
        endcase
    end

    always_comb begin
        eng_proto = req_q.proto;
        eng_tgt   = req_q.tgt;
        eng_read  = req_q.rd;
        eng_cmd   = req_q.cmd;
        eng_data  = req_q.data;
        eng_len   = req_q.len;
    end

endmodule

// File: rtl/smb_host_ctrl_chk.sv
module smb_host_ctrl_chk #(
    parameter  int BUF_DEPTH = 32,
    localparam int IW        = $clog2(BUF_DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [5:0]    reg_off,
    input logic          wr_start,
    input logic [2:0]    wr_proto,
    input logic          eng_req_valid,
    input logic          eng_req_ready,
    input logic [6:0]    eng_tgt,
    input logic [7:0]    eng_cmd,
    input logic [2:0]    eng_proto,
    input logic          eng_rsp_valid,
    input logic          busy,
    input logic          stat_done,
    input logic          stat_err,
    input logic [IW-1:0] blk_idx
);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        eng_req_valid && !eng_req_ready |=>
            eng_req_valid && $stable(eng_cmd) && $stable(eng_tgt) && $stable(eng_proto));

    assert_valid_busy_R6: assert property (@(posedge clk) disable iff (rst)
        eng_req_valid |-> busy);

    assert_done_on_rsp_R6: assert property (@(posedge clk) disable iff (rst)
        busy && !eng_req_valid && eng_rsp_valid |=> stat_done && !busy);

    assert_bad_proto_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_off == 6'd2 && wr_start && !busy &&
        (wr_proto == 3'd4 || wr_proto[2:1] == 2'b11) |=> stat_err && !eng_req_valid);

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        busy && reg_wr && reg_off == 6'd2 |=> $stable(eng_cmd) && $stable(eng_tgt) && $stable(eng_proto));

    assert_stat_clear_R9: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_off == 6'd0 && !eng_rsp_valid |=> !stat_done && !stat_err && blk_idx == '0);

    assert_ctl_read_idx_R10: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_off == 6'd2 |=> blk_idx == '0);

endmodule

bind smb_host_ctrl smb_host_ctrl_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_off       (reg_off),
    .wr_start      (reg_wdata[6]),
    .wr_proto      (reg_wdata[4:2]),
    .eng_req_valid (eng_req_valid),
    .eng_req_ready (eng_req_ready),
    .eng_tgt       (eng_tgt),
    .eng_cmd       (eng_cmd),
    .eng_proto     (eng_proto),
    .eng_rsp_valid (eng_rsp_valid),
    .busy          (busy),
    .stat_done     (stat_done),
    .stat_err      (stat_err),
    .blk_idx       (blk_idx)
);

// File: tb/smb_host_ctrl_bench.sv
module smb_host_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_off = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        eng_req_valid, eng_req_ready = 1'b0;
    logic [2:0]  eng_proto;
    logic [6:0]  eng_tgt;
    logic        eng_read;
    logic [7:0]  eng_cmd, eng_len;
    logic [15:0] eng_data;
    logic        eng_rsp_valid = 1'b0;
    logic [15:0] eng_rsp_data = '0;
    logic [4:0]  eng_buf_ridx = '0;
    logic [7:0]  eng_buf_rdata;
    logic        eng_buf_we = 1'b0;
    logic [4:0]  eng_buf_widx = '0;
    logic [7:0]  eng_buf_wdata = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    smb_host_ctrl u_smb_host_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
        .eng_proto(eng_proto), .eng_tgt(eng_tgt), .eng_read(eng_read),
        .eng_cmd(eng_cmd), .eng_data(eng_data), .eng_len(eng_len),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_data(eng_rsp_data),
        .eng_buf_ridx(eng_buf_ridx), .eng_buf_rdata(eng_buf_rdata),
        .eng_buf_we(eng_buf_we), .eng_buf_widx(eng_buf_widx), .eng_buf_wdata(eng_buf_wdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [5:0] off, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = off; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [5:0] off, output logic [7:0] val);
        @(negedge clk);
        reg_rd = 1'b1; reg_off = off;
        #1 val = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        host_rd(6'd0, v); check(v, 8'h00, "R6 status after reset");
        host_rd(6'd2, v); check(v, 8'h00, "R10 control after reset");
        check(eng_req_valid, 0, "R5 no request after reset");

        // register window
        host_wr(6'd3, 8'h5A); host_wr(6'd4, 8'hA7); host_wr(6'd5, 8'h3C); host_wr(6'd6, 8'hC3);
        host_wr(6'd1, 8'hFF);
        for (int o = 8; o < 64; o++) host_wr(6'(o), 8'hFF);
        host_rd(6'd1, v); check(v, 8'h00, "R1 offset 1 reads zero");
        for (int o = 8; o < 64; o++) begin
            host_rd(6'(o), v); check(v, 8'h00, "R1 unmapped offset reads zero");
        end
        host_rd(6'd3, v); check(v, 8'h5A, "R1 command readback");
        host_rd(6'd4, v); check(v, 8'hA7, "R1 address readback");
        host_rd(6'd5, v); check(v, 8'h3C, "R1 data0 readback");
        host_rd(6'd6, v); check(v, 8'hC3, "R1 data1 readback");
        host_rd(6'd0, v); check(v, 8'h00, "R1 status untouched by unmapped writes");

        // protocol sweep
        for (int p = 0; p < 8; p++) begin
            for (int rd = 0; rd < 2; rd++) begin
                logic [7:0]  cmd, adr, d0, d1, e0, e1;
                logic [15:0] rsp;
                bit ok;
                ok  = (p <= 3) || (p == 5);
                cmd = 8'(8'h10 + p * 2 + rd);
                adr = {7'(7'h20 + p), 1'(rd)};
                d0  = 8'(8'h40 + p);
                d1  = 8'(8'h80 + p);
                host_wr(6'd0, 8'h00);
                host_wr(6'd3, cmd); host_wr(6'd4, adr);
                host_wr(6'd5, d0);  host_wr(6'd6, d1);
                host_wr(6'd2, 8'(8'h40 | (p << 2)));
                if (!ok) begin
                    check(eng_req_valid, 0, "R4 no request for reserved code");
                    host_rd(6'd0, v); check(v, 8'h04, "R4 error bit set");
                    host_wr(6'd0, 8'h00);
                    host_rd(6'd0, v); check(v, 8'h00, "R9 status write clears error");
                    continue;
                end
                check(eng_req_valid, 1, "R2 request issued");
                check(eng_proto, 32'(p), "R2 protocol field");
                check(eng_tgt, adr[7:1], "R2 target field");
                check(eng_read, 32'(rd), "R2 read flag");
                check(eng_cmd, cmd, "R2 command field");
                check(eng_data, (p == 1 && rd == 0) ? {8'h00, cmd} : {d1, d0}, "R3 data field");
                check(eng_len, d0, "R3 length field");
                repeat (2) begin
                    @(negedge clk);
                    check(eng_req_valid, 1, "R5 valid held without ready");
                    check(eng_cmd, cmd, "R5 command stable");
                end
                eng_req_ready = 1'b1;
                @(negedge clk);
                eng_req_ready = 1'b0;
                check(eng_req_valid, 0, "R5 valid drops after ready");
                host_rd(6'd0, v); check(v, 8'h01, "R6 busy while waiting");
                if (p == 5 && rd == 1) begin
                    for (int k = 0; k < 4; k++) begin
                        @(negedge clk);
                        eng_buf_we = 1'b1; eng_buf_widx = 5'(k); eng_buf_wdata = 8'(8'hA0 + k);
                    end
                    @(negedge clk);
                    eng_buf_we = 1'b0;
                    rsp = 16'h0004;
                end else begin
                    rsp = {8'(8'hC0 + p), 8'(8'h30 + p)};
                end
                @(negedge clk);
                eng_rsp_valid = 1'b1; eng_rsp_data = rsp;
                @(negedge clk);
                eng_rsp_valid = 1'b0;
                host_rd(6'd0, v); check(v, 8'h02, "R6 done set, busy clear");
                e0 = d0; e1 = d1;
                if (rd == 1) begin
                    if (p == 1 || p == 2) e0 = 8'(8'h30 + p);
                    if (p == 3) begin e0 = 8'(8'h30 + p); e1 = 8'(8'hC0 + p); end
                    if (p == 5) e0 = 8'h04;
                end
                host_rd(6'd5, v); check(v, e0, "R7 data0 after completion");
                host_rd(6'd6, v); check(v, e1, "R7 data1 after completion");
                if (p == 5 && rd == 1) begin
                    host_wr(6'd0, 8'h00);
                    for (int k = 0; k < 4; k++) begin
                        host_rd(6'd7, v); check(v, 8'(8'hA0 + k), "R11 block read bytes");
                    end
                end
            end
        end

        // start while busy
        host_wr(6'd0, 8'h00);
        host_wr(6'd3, 8'h77);
        host_wr(6'd2, 8'h48);
        eng_req_ready = 1'b1;
        @(negedge clk);
        eng_req_ready = 1'b0;
        host_wr(6'd3, 8'h99);
        host_wr(6'd2, 8'h4C);
        check(eng_req_valid, 0, "R8 no request while busy");
        check(eng_cmd, 8'h77, "R8 in-flight command kept");
        @(negedge clk);
        eng_rsp_valid = 1'b1; eng_rsp_data = 16'h0000;
        @(negedge clk);
        eng_rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(eng_req_valid, 0, "R8 ignored start never issued");
        host_rd(6'd0, v); check(v, 8'h02, "R8 idle after completion");
        host_rd(6'd2, v); check(v, 8'h0C, "R8 control value stored");

        // control read masking
        host_wr(6'd2, 8'hBC);
        host_rd(6'd2, v); check(v, 8'h1C, "R10 control masked");
        host_rd(6'd0, v); check(v, 8'h02, "R10 no start from bit 7/5");

        // block buffer wrap
        host_wr(6'd0, 8'h00);
        for (int k = 0; k < 33; k++) host_wr(6'd7, 8'(k * 5 + 1));
        for (int k = 0; k < 32; k++) begin
            eng_buf_ridx = 5'(k);
            #1 check(eng_buf_rdata, (k == 0) ? 8'd161 : 8'(k * 5 + 1), "R11 engine read port after wrap");
        end
        host_rd(6'd2, v);
        for (int k = 0; k < 3; k++) begin
            host_rd(6'd7, v); check(v, (k == 0) ? 8'd161 : 8'(k * 5 + 1), "R10 pointer reset by control read");
        end
        host_wr(6'd0, 8'h00);
        host_rd(6'd7, v); check(v, 8'd161, "R9 pointer reset by status write");
        host_rd(6'd2, v);
        for (int k = 0; k < 34; k++) begin
            host_rd(6'd7, v);
            check(v, ((k % 32) == 0) ? 8'd161 : 8'((k % 32) * 5 + 1), "R11 pointer wraps after 31");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule